// File: doc/BRIEF.md
# Serial Four-Mode Word Shifter

This block shifts a 16-bit word by one bit per clock in one of four ways. The four ways are arithmetic left, arithmetic right with sign fill, circular right, and logical right with zero fill. The surrounding datapath provides the operand, a 4-bit count field taken from the instruction, the low four bits of workspace register 0 and a mode select. It then pulses `start` for one cycle. The block answers with `busy` while it shifts. It raises a one-cycle `done` when the final bit has moved, and at that point the result and its flags are valid.

The shift amount is chosen in two stages. A nonzero count field is used as it stands. A zero field hands the choice to the register-0 nibble, and a zero nibble there means a full shift of 16 places. The flags are carry, overflow, equal-to-zero, signed greater-than-zero and unsigned greater-than-zero. They describe the finished word and stay unchanged until the next accepted start.

Top module: `wsu_shifter`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `carry` and `overflow` are 0, `result` is 0x0000 and `eq_zero` is 1.
- R2: When `cnt_field` is nonzero, the word is shifted exactly `cnt_field` places.
- R3: When `cnt_field` is zero and `wr0_low` is nonzero, the word is shifted `wr0_low` places.
- R4: When both `cnt_field` and `wr0_low` are zero, the word is shifted 16 places.
- R5: Mode 0 (arithmetic left) moves bits toward the MSB and fills the LSB with 0. `carry` is the last bit that left bit 15.
- R6: Mode 1 (arithmetic right) moves bits toward the LSB and copies bit 15 into itself. `carry` is the last bit that left bit 0.
- R7: Mode 2 (circular right) feeds bit 0 back into bit 15. `carry` is the bit that entered bit 15 on the final step.
- R8: Mode 3 (logical right) moves bits toward the LSB and fills bit 15 with 0. `carry` is the last bit that left bit 0.
- R9: In mode 0, `overflow` is 1 when bit 15 changed value on any step of the shift. In modes 1 to 3, `overflow` is 0.
- R10: `eq_zero` is 1 exactly when `result` is 0. `gt_signed` is 1 when `result` is positive as a signed number. `gt_unsigned` is 1 when `result` is nonzero.
- R11: A start accepted at clock edge E raises `busy` from E to E+N-1, where N is the effective count. `done` is high for the single cycle after edge E+N. A `start` seen while `busy` is high is ignored, and `result` does not change while the unit is idle.
- R12: A `start` given in the same cycle that `done` is high is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a shift (taken only while idle) |
| mode | input | 2 | Shift kind: 0 arith left, 1 arith right, 2 circular right, 3 logical right |
| operand | input | 16 | Word to be shifted |
| cnt_field | input | 4 | Count field from the instruction |
| wr0_low | input | 4 | Low four bits of workspace register 0 |
| busy | output | 1 | Shift in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Shifted word |
| carry | output | 1 | Last bit moved out (or wrapped) |
| overflow | output | 1 | MSB changed during an arithmetic left shift |
| eq_zero | output | 1 | Result equals zero |
| gt_signed | output | 1 | Result greater than zero, signed |
| gt_unsigned | output | 1 | Result greater than zero, unsigned |

## Verification
Two things can land in the same cycle. One is the completion pulse of one shift. The other is the request for the next shift, or a stray request while the unit is still shifting. The bench starts each new shift in the very cycle where `done` is seen high, and checks that `busy` rises one edge later. Separately, it pulses `start` with a different operand partway through a long shift. Its cycle-level model ignores that request, so any leak of the second request shows up as a wrong result, a wrong flag or a shifted `done` time.

// File: rtl/wsu_pkg.sv
// Package: shared types for the serial word shifter.
// Assumes the mode encoding below is fixed by the instruction decoder.
package wsu_pkg;

    typedef enum logic [1:0] {
        SH_ALEFT  = 2'd0,
        SH_ARIGHT = 2'd1,
        SH_CIRC   = 2'd2,
        SH_LRIGHT = 2'd3
    } shift_kind_e;

endpackage

// File: rtl/wsu_count_sel.sv
// Module: resolves the effective shift amount.
// A nonzero instruction field wins. Otherwise the register-0 nibble is used,
// and a zero there means a full-width shift. Assumes WIDTH == 2**CNT_W.
module wsu_count_sel #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] field,
    input  logic [CNT_W-1:0] reg_low,
    output logic [CNT_W:0]   amount
);
    localparam logic [CNT_W:0] FULL = (CNT_W+1)'(1) << CNT_W;

    logic [CNT_W-1:0] picked;

    // choose the source, then map zero to the full width
    always_comb begin
        picked = (field != '0) ? field : reg_low;
        amount = (picked == '0) ? FULL : {1'b0, picked};
    end
endmodule

// File: rtl/wsu_step.sv
// Module: one single-bit shift step for the selected kind.
// It reports the bit that leaves the word and whether the MSB would flip.
// Purely combinational; the sequencer registers its outputs.
module wsu_step
    import wsu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  shift_kind_e      kind,
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] next,
    output logic             bit_out,
    output logic             msb_flip
);
    // form the next word and the departing bit
    always_comb begin
        msb_flip = 1'b0;
        unique case (kind)
            SH_ALEFT: begin
                next     = {word[WIDTH-2:0], 1'b0};
                bit_out  = word[WIDTH-1];
                msb_flip = word[WIDTH-1] ^ word[WIDTH-2];
            end
            SH_ARIGHT: begin
                next    = {word[WIDTH-1], word[WIDTH-1:1]};
                bit_out = word[0];
            end
            SH_CIRC: begin
                next    = {word[0], word[WIDTH-1:1]};
                bit_out = word[0];
            end
            default: begin
                next    = {1'b0, word[WIDTH-1:1]};
                bit_out = word[0];
            end
        endcase
    end
endmodule

// File: rtl/wsu_flags.sv
// Module: comparison flags of a word against zero.
// Combinational; the word is read as two's complement for the signed flag.
module wsu_flags #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] word,
    output logic             is_zero,
    output logic             pos_signed,
    output logic             pos_unsigned
);
    // compare the word against zero both ways
    always_comb begin
        is_zero      = (word == '0);
        pos_unsigned = !is_zero;
        pos_signed   = !word[WIDTH-1] && !is_zero;
    end
endmodule

// File: rtl/wsu_shifter.sv
// Module: serial shifter top with a start/done handshake.
// It loads on an idle start, shifts one bit per cycle for the resolved
// count, then pulses done. Results and flags hold until the next start.
// Assumes start is a level sampled each clock; requests while busy are ignored.
module wsu_shifter
    import wsu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] operand,
    input  logic [$clog2(WIDTH)-1:0] cnt_field,
    input  logic [$clog2(WIDTH)-1:0] wr0_low,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result,
    output logic             carry,
    output logic             overflow,
    output logic             eq_zero,
    output logic             gt_signed,
    output logic             gt_unsigned
);
    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W:0] ONE  = (CNT_W+1)'(1);
    localparam logic [CNT_W:0] FULL = (CNT_W+1)'(WIDTH);

    logic [WIDTH-1:0] acc_q;
    logic [CNT_W:0]   left_q;
    logic             busy_q, done_q, carry_q, ovf_q;
    shift_kind_e      kind_q;

    logic [CNT_W:0]   amount;
    logic [WIDTH-1:0] step_next;
    logic             step_out, step_flip;

    wsu_count_sel #(.CNT_W(CNT_W)) u_cnt (
        .field   (cnt_field),
        .reg_low (wr0_low),
        .amount  (amount)
    );

    wsu_step #(.WIDTH(WIDTH)) u_step (
        .kind     (kind_q),
        .word     (acc_q),
        .next     (step_next),
        .bit_out  (step_out),
        .msb_flip (step_flip)
    );

    wsu_flags #(.WIDTH(WIDTH)) u_flags (
        .word         (acc_q),
        .is_zero      (eq_zero),
        .pos_signed   (gt_signed),
        .pos_unsigned (gt_unsigned)
    );

    // sequencer: load on idle start, step while busy, pulse done at the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            left_q  <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            carry_q <= 1'b0;
            ovf_q   <= 1'b0;
            kind_q  <= SH_ALEFT;
        end else begin
            done_q <= 1'b0;
            if (busy_q) begin
                acc_q   <= step_next;
                carry_q <= step_out;
                if (kind_q == SH_ALEFT && step_flip)
                    ovf_q <= 1'b1;
                left_q <= left_q - ONE;
                if (left_q == ONE) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end else if (start) begin
                acc_q   <= operand;
                left_q  <= amount;
                busy_q  <= 1'b1;
                carry_q <= 1'b0;
                ovf_q   <= 1'b0;
                kind_q  <= shift_kind_e'(mode);
            end
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign result   = acc_q;
    assign carry    = carry_q;
    assign overflow = ovf_q;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start) |=> $stable(acc_q));

    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_q) |=> (left_q != '0 && left_q <= FULL));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && kind_q != SH_ALEFT) |-> !ovf_q);

    // R10
    zero_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eq_zero |-> (!gt_signed && !gt_unsigned));
endmodule

// File: tb/wsu_shifter_bench.sv
// Bench: behavioural cycle model compared with the shifter on every clock.
module wsu_shifter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [15:0] operand = '0;
    logic [3:0]  cnt_field = '0;
    logic [3:0]  wr0_low = '0;
    logic        busy, done, carry, overflow, eq_zero, gt_signed, gt_unsigned;
    logic [15:0] result;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    wsu_shifter u_wsu_shifter (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .operand(operand), .cnt_field(cnt_field), .wr0_low(wr0_low),
        .busy(busy), .done(done), .result(result), .carry(carry),
        .overflow(overflow), .eq_zero(eq_zero), .gt_signed(gt_signed),
        .gt_unsigned(gt_unsigned)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference: whole shift computed in one go
    task automatic ref_shift(input int k, input logic [15:0] op, input int n,
                             output logic [15:0] r, output logic c, output logic v);
        r = op; c = 1'b0; v = 1'b0;
        for (int i = 0; i < n; i++) begin
            case (k)
                0: begin
                    c = r[15];
                    if (r[15] != r[14]) v = 1'b1;
                    r = r << 1;
                end
                1: begin c = r[0]; r = {r[15], r[15:1]}; end
                2: begin c = r[0]; r = {r[0], r[15:1]}; end
                default: begin c = r[0]; r = r >> 1; end
            endcase
        end
    endtask

    // cycle model state
    logic        m_busy = 1'b0, m_done = 1'b0, m_c = 1'b0, m_v = 1'b0;
    logic [15:0] m_res = '0;
    int          m_left = 0;
    string       m_cnt_tag = "R2";
    string       m_mode_tag = "R5";

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy <= 1'b0; m_done <= 1'b0; m_left <= 0;
        end else begin
            m_done <= 1'b0;
            if (m_busy) begin
                if (m_left == 1) begin m_busy <= 1'b0; m_done <= 1'b1; end
                m_left <= m_left - 1;
            end else if (start) begin
                int n;
                logic [15:0] r; logic c, v;
                if (cnt_field != 0) begin n = cnt_field; m_cnt_tag <= "R2"; end
                else if (wr0_low != 0) begin n = wr0_low; m_cnt_tag <= "R3"; end
                else begin n = 16; m_cnt_tag <= "R4"; end
                ref_shift(int'(mode), operand, n, r, c, v);
                m_res <= r; m_c <= c; m_v <= v;
                m_busy <= 1'b1; m_left <= n;
                case (mode)
                    2'd0: m_mode_tag <= "R5";
                    2'd1: m_mode_tag <= "R6";
                    2'd2: m_mode_tag <= "R7";
                    default: m_mode_tag <= "R8";
                endcase
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == m_busy, "R11", "busy", {15'd0, busy}, {15'd0, m_busy});
            chk(done == m_done, m_cnt_tag, "done timing", {15'd0, done}, {15'd0, m_done});
            if (m_done) begin
                chk(result == m_res, m_mode_tag, "result", result, m_res);
                chk(carry == m_c, m_mode_tag, "carry", {15'd0, carry}, {15'd0, m_c});
                chk(overflow == m_v, "R9", "overflow", {15'd0, overflow}, {15'd0, m_v});
                chk(eq_zero == (m_res == 0), "R10", "eq_zero",
                    {15'd0, eq_zero}, {15'd0, m_res == 0});
                chk(gt_signed == (!m_res[15] && m_res != 0), "R10", "gt_signed",
                    {15'd0, gt_signed}, {15'd0, (!m_res[15] && m_res != 0)});
                chk(gt_unsigned == (m_res != 0), "R10", "gt_unsigned",
                    {15'd0, gt_unsigned}, {15'd0, m_res != 0});
            end
        end
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cyc > 50000) begin
            total++; bad++;
            $display("FAIL watchdog expired act=%0d exp=<50000", cyc);
            finish_run();
        end
    end

    // one shift; poke>0 fires a stray start that many cycles in
    task automatic run(input int k, input logic [15:0] op, input logic [3:0] fld,
                       input logic [3:0] r0, input int poke);
        bit chained;
        chained = done;
        mode = 2'(k); operand = op; cnt_field = fld; wr0_low = r0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (chained)
            chk(busy == 1'b1, "R12", "start in done cycle", {15'd0, busy}, 16'd1);
        for (int i = 0; i < poke; i++) @(negedge clk);
        if (poke > 0) begin
            mode = 2'(k + 1); operand = ~op; cnt_field = 4'd1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(result == 16'h0000, "R1", "result", result, 16'h0000);
        chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done", {14'd0, busy, done}, 16'd0);
        chk(carry == 1'b0 && overflow == 1'b0, "R1", "carry/ovf",
            {14'd0, carry, overflow}, 16'd0);
        chk(eq_zero == 1'b1, "R1", "eq_zero", {15'd0, eq_zero}, 16'd1);

        run(0, 16'h1234, 4'd3, 4'd0, 0);   // R2 R5
        run(0, 16'h4000, 4'd1, 4'd0, 0);   // R9 overflow set
        run(0, 16'hC000, 4'd1, 4'd0, 0);   // R9 no flip
        run(0, 16'hC000, 4'd2, 4'd0, 0);   // R9 flip on second step, zero result
        run(1, 16'h8001, 4'd0, 4'd4, 0);   // R3 R6
        run(1, 16'h8000, 4'd0, 4'd0, 0);   // R4 full sign fill
        run(2, 16'h0001, 4'd1, 4'd9, 0);   // R7 wrap, field wins
        run(2, 16'h1234, 4'd0, 4'd0, 0);   // R4 R7 full rotate
        run(3, 16'h8000, 4'd15, 4'd0, 0);  // R8
        run(3, 16'hFFFF, 4'd0, 4'd0, 0);   // R4 R8 all out
        run(1, 16'h7FFE, 4'd12, 4'd0, 3);  // R11 stray start ignored
        run(0, 16'h00FF, 4'd0, 4'd0, 5);   // R11 stray start ignored
        for (int i = 0; i < 48; i++)
            run(i % 4, 16'(i * 16'h3C5B ^ 16'hA11C), 4'(i % 5), 4'(i * 7), 0);
        repeat (3) @(negedge clk);
        // R11 idle hold
        chk(busy == 1'b0 && done == 1'b0, "R11", "idle", {14'd0, busy, done}, 16'd0);
        finish_run();
    end
endmodule